// File: doc/BRIEF.md
# Oscillator Enable-Ready Controller

This block tracks the start/ready handshake for eight clock sources: a multi-speed internal oscillator, an internal high-speed oscillator, an external high-speed oscillator, a main PLL, two auxiliary PLLs, and internal and external low-speed oscillators. Software turns a source on or off by writing its enable bit in a control register. The ready bit for that source then follows at once. Actual start-up delays are not modelled. The block also holds an interrupt-enable mask, a sticky event-flag register and a write-one-to-clear port for those flags. A single registered interrupt line is high while any flag is set.

The block takes a 2-bit code that reports which source currently drives the system clock. That source is protected from being stopped:
- A request to turn off the main PLL or the external high-speed oscillator is ignored while that source is selected.
- The multi-speed and internal high-speed oscillators are forced on and ready by any control write while they are selected.

Register access uses a simple port. A write is committed on the clock edge where `bus_sel` and `bus_wr` are both high. A read is combinational while `bus_sel` is high and `bus_wr` is low.

Top module: `osc_ready_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00000063, the interrupt-enable register (address 1) and the flag register (address 2) read 0, and `irq_o` is 0.
- R2: Each source has an enable bit and a ready bit at the next position up. The enable/ready positions are: multi-speed 0/1, internal high-speed 8/9, internal low-speed 12/13, external low-speed 14/15, external high-speed 16/17, main PLL 24/25, auxiliary PLL A 26/27, auxiliary PLL B 28/29. Writing 1 to an enable bit sets that bit and its ready bit, visible from the edge that commits the write.
- R3: A control write with an enable bit at 1 sets that source's flag only if its interrupt-enable bit is 1. Flag and interrupt-enable bit index per source: multi-speed 0, internal high-speed 1, external high-speed 2, main PLL 3, auxiliary A 4, auxiliary B 5, internal low-speed 6, external low-speed 7.
- R4: Writing 0 to an enable bit clears that enable bit and its ready bit, unless R5 to R8 apply.
- R5: While `clk_status` is 3, a control write with the main PLL enable at 0 leaves the PLL enable and ready bits unchanged.
- R6: While `clk_status` is 2, a control write with the external high-speed enable at 0 leaves its enable and ready bits unchanged.
- R7: While `clk_status` is 1, any control write leaves the internal high-speed oscillator on and ready, and sets its flag if that flag is enabled.
- R8: While `clk_status` is 0, any control write leaves the multi-speed oscillator on and ready. Its flag is set only if its enable bit was 0 before the write and the flag is enabled.
- R9: A write to the flag register (address 2) changes no flag.
- R10: Writing to the clear register (address 3) clears each flag whose bit is 1 in the written data. Reading address 3 returns 0.
- R11: `irq_o` is a register output. It is 1 exactly when at least one flag is set, and it changes on the same edge as the flags.
- R12: Ready bits are read-only. Bits 7:4 of the control register form a plain read/write range field. Reset value 6. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 interrupt enable, 2 flags, 3 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is selected |
| clk_status | input | 2 | Code of the source driving the system clock |
| irq_o | output | 1 | Interrupt, high while any flag is set |

## Verification
Two behaviours can land in the same cycle:
- the `clk_status` code can change in the very cycle of a control write;
- a single write can at once refuse an off request, force a source on, and raise flags for other sources.

The bench provokes both by drawing a fresh random status code with every write. It then judges the outcome against a bench model that applies the status seen at the committing edge. Directed cases aim at each protected source with and without a prior enable, and at the multi-speed flag-only-from-off rule.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned ST_W      = 2;
  localparam int unsigned NUM_OSC   = 8;
  localparam int unsigned RANGE_LSB = 4;
  localparam int unsigned RANGE_W   = 4;
  localparam logic [RANGE_W-1:0] RANGE_RST = 4'd6;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_IEN  = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_CLR  = 2'd3
  } reg_addr_e;

  // source index = flag / interrupt-enable bit index
  localparam int unsigned OSC_MSPD  = 0;
  localparam int unsigned OSC_IHS   = 1;
  localparam int unsigned OSC_EHS   = 2;
  localparam int unsigned OSC_MPLL  = 3;
  localparam int unsigned OSC_APLLA = 4;
  localparam int unsigned OSC_APLLB = 5;
  localparam int unsigned OSC_ILS   = 6;
  localparam int unsigned OSC_ELS   = 7;

  // system clock status codes
  localparam logic [ST_W-1:0] ST_MSPD = 2'd0;
  localparam logic [ST_W-1:0] ST_IHS  = 2'd1;
  localparam logic [ST_W-1:0] ST_EHS  = 2'd2;
  localparam logic [ST_W-1:0] ST_MPLL = 2'd3;

  // enable bit position in control word; ready sits one above
  function automatic int unsigned en_pos(int unsigned i);
    case (i)
      OSC_MSPD:  return 0;
      OSC_IHS:   return 8;
      OSC_EHS:   return 16;
      OSC_MPLL:  return 24;
      OSC_APLLA: return 26;
      OSC_APLLB: return 28;
      OSC_ILS:   return 12;
      default:   return 14;
    endcase
  endfunction

  function automatic bit is_forced(int unsigned i);
    return (i == OSC_MSPD) || (i == OSC_IHS);
  endfunction

  function automatic logic [ST_W-1:0] force_code(int unsigned i);
    return (i == OSC_MSPD) ? ST_MSPD : ST_IHS;
  endfunction

  function automatic bit is_locked(int unsigned i);
    return (i == OSC_EHS) || (i == OSC_MPLL);
  endfunction

  function automatic logic [ST_W-1:0] lock_code(int unsigned i);
    return (i == OSC_EHS) ? ST_EHS : ST_MPLL;
  endfunction

  function automatic bit flag_from_off(int unsigned i);
    return (i == OSC_MSPD);
  endfunction

  function automatic bit reset_on(int unsigned i);
    return (i == OSC_MSPD);
  endfunction
endpackage

// File: rtl/osc_lane.sv
module osc_lane #(
  parameter int unsigned ST_W = 2,
  parameter bit RST_ON = 1'b0,
  parameter bit FORCE_EN = 1'b0,
  parameter logic [ST_W-1:0] FORCE_CODE = '0,
  parameter bit LOCK_EN = 1'b0,
  parameter logic [ST_W-1:0] LOCK_CODE = '0,
  parameter bit FROM_OFF_ONLY = 1'b0
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            ctrl_wr,
  input  logic            en_wr,
  input  logic            ien,
  input  logic [ST_W-1:0] status,
  output logic            en_q,
  output logic            rdy_q,
  output logic            raise
);
  logic en_d, rdy_d;
  logic forced, locked;

  assign forced = FORCE_EN && (status == FORCE_CODE);
  assign locked = LOCK_EN && (status == LOCK_CODE);

  always_comb begin
    en_d  = en_q;
    rdy_d = rdy_q;
    raise = 1'b0;
    if (ctrl_wr) begin
      if (forced) begin
        en_d  = 1'b1;
        rdy_d = 1'b1;
        raise = ien && (!FROM_OFF_ONLY || !en_q);
      end else if (locked && !en_wr) begin
        en_d  = en_q;
        rdy_d = rdy_q;
      end else begin
        en_d  = en_wr;
        rdy_d = en_wr;
        raise = ien && en_wr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= RST_ON;
      rdy_q <= RST_ON;
    end else if (ctrl_wr) begin
      en_q  <= en_d;
      rdy_q <= rdy_d;
    end
  end

  // ready never stands without its enable
  assert_rdy_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    rdy_q |-> en_q);

  assert_lock_keeps_on_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && locked && en_q) |=> en_q);

  assert_forced_on_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && forced) |=> (en_q && rdy_q));

  assert_raise_needs_ien_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    raise |-> (ien && ctrl_wr));
endmodule

// File: rtl/osc_flags.sv
module osc_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] raise,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags_q,
  output logic         irq_o
);
  logic [N-1:0] flags_d;
  logic [N-1:0] kill;
  logic         irq_d;

  assign kill = clr_wr ? clr_mask : '0;

  always_comb begin
    flags_d = (flags_q | raise) & ~kill;
    irq_d   = |flags_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_o   <= irq_d;
    end
  end

  assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_wr |=> ((flags_q & $past(clr_mask)) == '0));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o == (|flags_q));
endmodule

// File: rtl/osc_ready_ctrl.sv
module osc_ready_ctrl
  import osc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [ST_W-1:0]     clk_status,
  output logic                irq_o
);
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic ctrl_wr, ien_wr, clr_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
  assign ien_wr  = bus_sel && bus_wr && (bus_addr == ADR_IEN);
  assign clr_wr  = bus_sel && bus_wr && (bus_addr == ADR_CLR);

  logic [RANGE_W-1:0] range_q, range_d;
  logic [NUM_OSC-1:0] ien_q, ien_d;

  always_comb begin
    range_d = range_q;
    ien_d   = ien_q;
    if (ctrl_wr) range_d = bus_wdata[RANGE_LSB +: RANGE_W];
    if (ien_wr)  ien_d   = bus_wdata[NUM_OSC-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= RANGE_RST;
      ien_q   <= '0;
    end else begin
      if (ctrl_wr) range_q <= range_d;
      if (ien_wr)  ien_q   <= ien_d;
    end
  end

  logic [NUM_OSC-1:0] en_q, rdy_q, raise;

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_lane
    osc_lane #(
      .ST_W(ST_W),
      .RST_ON(reset_on(i)),
      .FORCE_EN(is_forced(i)),
      .FORCE_CODE(force_code(i)),
      .LOCK_EN(is_locked(i)),
      .LOCK_CODE(lock_code(i)),
      .FROM_OFF_ONLY(flag_from_off(i))
    ) u_lane (
      .clk(clk),
      .rst_ni(rst_ni),
      .ctrl_wr(ctrl_wr),
      .en_wr(bus_wdata[en_pos(i)]),
      .ien(ien_q[i]),
      .status(clk_status),
      .en_q(en_q[i]),
      .rdy_q(rdy_q[i]),
      .raise(raise[i])
    );
  end

  logic [NUM_OSC-1:0] flags_q;

  osc_flags #(.N(NUM_OSC)) u_flags (
    .clk(clk),
    .rst_ni(rst_ni),
    .raise(raise),
    .clr_wr(clr_wr),
    .clr_mask(bus_wdata[NUM_OSC-1:0]),
    .flags_q(flags_q),
    .irq_o(irq_o)
  );

  logic [DATA_W-1:0] ctrl_img;

  always_comb begin
    ctrl_img = '0;
    ctrl_img[RANGE_LSB +: RANGE_W] = range_q;
    for (int unsigned i = 0; i < NUM_OSC; i++) begin
      ctrl_img[en_pos(i)]     = en_q[i];
      ctrl_img[en_pos(i) + 1] = rdy_q[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADR_CTRL: bus_rdata = ctrl_img;
        ADR_IEN:  bus_rdata = {{(DATA_W-NUM_OSC){1'b0}}, ien_q};
        ADR_FLAG: bus_rdata = {{(DATA_W-NUM_OSC){1'b0}}, flags_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_range_rw_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr |=> (range_q == $past(bus_wdata[RANGE_LSB +: RANGE_W])));

  assert_ien_held_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !ien_wr |=> $stable(ien_q));

  assert_no_side_write_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_sel && bus_wr && bus_addr == ADR_FLAG) |=> ($stable(en_q) && $stable(ien_q)));
endmodule

// File: tb/sim_osc_ready_ctrl.sv
`timescale 1ns/1ps
module sim_osc_ready_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  clk_status;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  osc_ready_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_status(clk_status), .irq_o(irq_o)
  );

  // bench model
  bit       m_en [8];
  bit       m_rdy[8];
  bit [3:0] m_range;
  bit [7:0] m_ien, m_flags;

  function automatic int pos(int i);
    case (i)
      0: return 0;  1: return 8;  2: return 16; 3: return 24;
      4: return 26; 5: return 28; 6: return 12; default: return 14;
    endcase
  endfunction

  function automatic bit [31:0] m_ctrl();
    bit [31:0] v = 0;
    v[7:4] = m_range;
    for (int i = 0; i < 8; i++) begin
      v[pos(i)]   = m_en[i];
      v[pos(i)+1] = m_rdy[i];
    end
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_en[i] = (i == 0); m_rdy[i] = (i == 0); end
    m_range = 4'd6; m_ien = 0; m_flags = 0;
  endtask

  task automatic m_ctrl_write(bit [31:0] v, bit [1:0] s);
    for (int i = 0; i < 8; i++) begin
      bit w  = v[pos(i)];
      bit fo = (i == 0 && s == 0) || (i == 1 && s == 1);
      bit lk = (i == 2 && s == 2) || (i == 3 && s == 3);
      if (fo) begin
        if (m_ien[i] && (i != 0 || !m_en[i])) m_flags[i] = 1;
        m_en[i] = 1; m_rdy[i] = 1;
      end else if (lk && !w) begin
        // refused: hold
      end else begin
        m_en[i] = w; m_rdy[i] = w;
        if (w && m_ien[i]) m_flags[i] = 1;
      end
    end
    m_range = v[7:4];
  endtask

  task automatic do_write(bit [1:0] a, bit [31:0] d, bit [1:0] s);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; clk_status = s;
    case (a)
      2'd0: m_ctrl_write(d, s);
      2'd1: m_ien = d[7:0];
      2'd3: m_flags = m_flags & ~d[7:0];
      default: ;
    endcase
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(bit [1:0] a, output bit [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    bit [31:0] v;
    rd(2'd0, v); chk({tag, " R2 ctrl"}, v, m_ctrl());
    rd(2'd1, v); chk({tag, " R3 ien"}, v, {24'd0, m_ien});
    rd(2'd2, v); chk({tag, " R9 flags"}, v, {24'd0, m_flags});
    rd(2'd3, v); chk({tag, " R10 clr reads 0"}, v, 0);
    chk({tag, " R11 irq"}, {31'd0, irq_o}, {31'd0, |m_flags});
  endtask

  initial begin
    bit [31:0] v;
    void'($urandom(32'h5EED_0C11));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; clk_status = 2'd2;
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0000_0063);
    rd(2'd1, v); chk("R1 ien", v, 0);
    rd(2'd2, v); chk("R1 flags", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R12 ready bits read-only
    do_write(0, 32'hAA02_A20A, 2);
    rd(0, v); chk("R12 ready ro", v, 32'h0);
    // R3 no flag without enable
    do_write(0, 32'h100, 2);
    rd(0, v); chk("R2 ihs on", v, 32'h300);
    rd(2, v); chk("R3 no flag", v, 0);
    // R3 flags with enable
    do_write(1, 32'hFF, 2);
    do_write(0, 32'h10100, 2);
    rd(0, v); chk("R2 ehs on", v, 32'h30300);
    rd(2, v); chk("R3 flags", v, 32'h06);
    chk("R11 irq high", {31'd0, irq_o}, 1);
    // R9 flag write ignored
    do_write(2, 32'h0, 2);
    rd(2, v); chk("R9 flag write", v, 32'h06);
    // R10 clear
    do_write(3, 32'h02, 2);
    rd(2, v); chk("R10 partial clear", v, 32'h04);
    chk("R11 irq still", {31'd0, irq_o}, 1);
    do_write(3, 32'h04, 2);
    chk("R11 irq low", {31'd0, irq_o}, 0);
    // R6 ehs off refused
    do_write(0, 32'h100, 2);
    rd(0, v); chk("R6 ehs kept", v, 32'h30300);
    do_write(3, 32'hFF, 2);
    // R8 + R4
    do_write(0, 32'h100, 0);
    rd(0, v); chk("R8/R4 ctrl", v, 32'h303);
    rd(2, v); chk("R8 flag from off", v, 32'h03);
    do_write(3, 32'hFF, 0);
    do_write(0, 32'h100, 0);
    rd(2, v); chk("R8 no flag when on", v, 32'h02);
    do_write(3, 32'hFF, 0);
    // R5 main PLL off refused
    do_write(0, 32'h0100_0100, 0);
    do_write(0, 32'h100, 3);
    rd(0, v); chk("R5 pll kept", v, 32'h0300_0300);
    do_write(3, 32'hFF, 3);
    // R7 ihs forced
    do_write(0, 32'h0, 1);
    rd(0, v); chk("R7 ihs forced", v, 32'h300);
    rd(2, v); chk("R7 flag", v, 32'h02);
    do_write(3, 32'hFF, 1);
    // R2 low-speed and aux sources
    do_write(0, 32'h1400_5000, 2);
    rd(0, v); chk("R2 others", v, 32'h3C00_F000);
    rd(2, v); chk("R3 others flags", v, 32'hF0);
    // R12 range field
    do_write(0, 32'h50, 3);
    rd(0, v); chk("R12 range", v, 32'h50);
    chk_all("directed");

    // random phase
    for (int n = 0; n < 400; n++) begin
      bit [1:0]  a = 2'($urandom_range(0, 3));
      bit [31:0] d = $urandom;
      bit [1:0]  s = 2'($urandom_range(0, 3));
      do_write(a, d, s);
      chk_all("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule